// File: doc/BRIEF.md
# Calendar Counter with Hold-for-Access

The block keeps wall-clock time and a calendar. A sub-second counter advances on every strobe of a slow 32.768 kHz time base, and each wrap of that counter moves a chain of seconds, minutes, hours, day, month and year counters forward by one second. Software reaches every counter through a small byte-wide register port.

Reading or changing a multi-field time value while it moves gives torn results. Software therefore first sets a hold bit. The calendar chain then stops, but the sub-second counter keeps running. One slow-clock strobe later a ready bit tells software that the fields may be read and written. A second that elapses during the hold is remembered and added once when the hold is released. Writing the seconds field restarts the sub-second phase and drops that remembered second.

Two event sources share one interrupt line and keep separate sticky flags. The periodic event fires every second or every minute. The alarm event fires when the time reaches a programmed hour and minute. Software clears a flag by writing 0 to its bit. Writing 1 leaves the flag untouched, so a full-byte write to the control register cannot drop an event that arrives in the meantime.

Top module: `rtc_hold_core`

## Requirements
- R1: While the hold bit (control bit 0) is 1, the seconds, minutes, hours, day, month and year fields do not advance.
- R2: The sub-second counter of SUB_W bits advances on every `tick` strobe, including during a hold. When it wraps from all-ones to zero and no hold is set, seconds increases by one, and the new value is readable in the clock cycle after that strobe.
- R3: The ready bit (control bit 1) becomes 1 on the first `tick` after hold is set and returns to 0 in the cycle after hold is cleared. Writes to the calendar fields (addresses 0 to 5) are ignored while ready is 0.
- R4: If the sub-second counter wraps one or more times during a hold, seconds increases by exactly one within two cycles after the hold is cleared.
- R5: A write to seconds (address 0) clears the sub-second counter to zero and discards any second owed from a hold.
- R6: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into day. Day wraps to 1 after the month's last day and carries into month. Month wraps from 12 to 1 and carries into year. Year wraps from YEAR_MAX to 0.
- R7: Months 4, 6, 9 and 11 have 30 days. Month 2 has 29 days when the two low bits of the year are 0 and 28 days otherwise. All other months have 31 days.
- R8: The periodic flag (control bit 2) sets on every one-second step when the period bit (control bit 4) is 0. When the period bit is 1, it sets only on steps where seconds wrap to 0.
- R9: When alarm enable (control bit 5) is 1, the alarm flag (control bit 3) sets on a step where seconds wrap to 0 and the resulting hour and minute equal the alarm hour (address 7) and alarm minute (address 6).
- R10: A control write (address 8) with 0 in a flag bit clears that flag. A control write with 1 in a flag bit leaves that flag unchanged. `irq` is 1 exactly when at least one flag is 1.
- R11: After reset the time is 00:00:00 on day 1 of month 1, year 0, the control register reads 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe at the 32.768 kHz rate, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address: 0 sec, 1 min, 2 hour, 3 day, 4 month, 5 year, 6 alarm minute, 7 alarm hour, 8 control |
| wdata | input | 8 | Write data, binary values |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Shared event interrupt, level |

## Verification
The assertions check every cycle that the calendar fields stay frozen during a hold unless they are written, that the sub-second counter steps on each strobe, that ready rises only on a strobe and falls once hold drops, and that a remembered second appears only under a hold. They also check that a seconds write leaves no owed second and that the event flags obey the keep-on-1 and clear-on-0 write rule. Only the bench scenarios can show the calendar values themselves. These include month lengths across leap and common years, the full rollover chain, an owed second arriving exactly once after a long hold, its cancellation by a seconds write, and alarm matching.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   localparam int unsigned DW = 8;

   typedef enum logic [3:0] {
      A_SEC   = 4'd0,
      A_MIN   = 4'd1,
      A_HOUR  = 4'd2,
      A_DAY   = 4'd3,
      A_MONTH = 4'd4,
      A_YEAR  = 4'd5,
      A_AMIN  = 4'd6,
      A_AHOUR = 4'd7,
      A_CTRL  = 4'd8
   } rtc_addr_e;

   // control bit positions
   localparam int unsigned C_HOLD  = 0;
   localparam int unsigned C_READY = 1;
   localparam int unsigned C_FIX   = 2;
   localparam int unsigned C_ALM   = 3;
   localparam int unsigned C_PER   = 4;
   localparam int unsigned C_AEN   = 5;

   function automatic logic [DW-1:0] month_len(input logic [DW-1:0] mon,
                                               input logic [DW-1:0] yr);
      logic [DW-1:0] r;
      case (mon)
         8'd2:                 r = (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
         8'd4, 8'd6, 8'd9, 8'd11: r = 8'd30;
         default:              r = 8'd31;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/rtc_subsec.sv
module rtc_subsec #(
   parameter int unsigned SUB_W = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic hold,
   input  logic clr,
   output logic step,
   output logic ready
);
   localparam logic [SUB_W-1:0] SUB_TOP = {SUB_W{1'b1}};

   logic [SUB_W-1:0] sub;
   logic             owed;
   logic             wrap;

   assign wrap = tick && (sub == SUB_TOP);
   assign step = !hold && (wrap || owed);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub   <= '0;
         owed  <= 1'b0;
         ready <= 1'b0;
      end else begin
         if (clr)       sub <= '0;
         else if (tick) sub <= sub + 1'b1;

         if (clr)       owed <= 1'b0;
         else if (hold) owed <= owed || wrap;
         else           owed <= owed && wrap;

         if (!hold)     ready <= 1'b0;
         else if (tick) ready <= 1'b1;
      end
   end

   AST_SUB_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !clr) |=> (sub == $past(sub) + 1'b1)); // R2
   AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(tick)); // R3
   AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !hold |=> !ready); // R3
   AST_OWED_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(owed) |-> $past(hold)); // R4
   AST_CLR_FORGETS: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (sub == '0) && !owed); // R5

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import rtc_pkg::*;
#(
   parameter int unsigned YEAR_MAX = 99
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          hold,
   input  logic [5:0]    fld_we,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] sec,
   output logic [DW-1:0] min,
   output logic [DW-1:0] hour,
   output logic [DW-1:0] day,
   output logic [DW-1:0] month,
   output logic [DW-1:0] year,
   output logic          sec_last,
   output logic [DW-1:0] min_nxt,
   output logic [DW-1:0] hour_nxt
);
   localparam logic [DW-1:0] YMAX = DW'(YEAR_MAX);

   logic min_last, hour_last;

   assign sec_last  = (sec >= 8'd59);
   assign min_last  = (min >= 8'd59);
   assign hour_last = (hour >= 8'd23);
   assign min_nxt   = !sec_last ? min : (min_last ? '0 : min + 1'b1);
   assign hour_nxt  = !(sec_last && min_last) ? hour : (hour_last ? '0 : hour + 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec   <= '0;
         min   <= '0;
         hour  <= '0;
         day   <= 8'd1;
         month <= 8'd1;
         year  <= '0;
      end else if (step) begin
         sec  <= sec_last ? '0 : sec + 1'b1;
         min  <= min_nxt;
         hour <= hour_nxt;
         if (sec_last && min_last && hour_last) begin
            if (day >= month_len(month, year)) begin
               day <= 8'd1;
               if (month >= 8'd12) begin
                  month <= 8'd1;
                  year  <= (year >= YMAX) ? '0 : year + 1'b1;
               end else begin
                  month <= month + 1'b1;
               end
            end else begin
               day <= day + 1'b1;
            end
         end
      end else begin
         if (fld_we[0]) sec   <= wdata;
         if (fld_we[1]) min   <= wdata;
         if (fld_we[2]) hour  <= wdata;
         if (fld_we[3]) day   <= wdata;
         if (fld_we[4]) month <= wdata;
         if (fld_we[5]) year  <= wdata;
      end
   end

   AST_FROZEN_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && (fld_we == '0)) |=> $stable({sec, min, hour, day, month, year})); // R1
   AST_SEC_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !sec_last) |=> (sec == $past(sec) + 1'b1)); // R2

endmodule

// File: rtl/rtc_events.sv
module rtc_events
   import rtc_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          sec_last,
   input  logic [DW-1:0] min_nxt,
   input  logic [DW-1:0] hour_nxt,
   input  logic [DW-1:0] alm_min,
   input  logic [DW-1:0] alm_hour,
   input  logic          per_min,
   input  logic          alm_en,
   input  logic          ctrl_we,
   input  logic          keep_fix,
   input  logic          keep_alm,
   output logic          fix_flag,
   output logic          alm_flag,
   output logic          irq
);
   logic set_fix, set_alm;

   assign set_fix = step && (!per_min || sec_last);
   assign set_alm = step && sec_last && alm_en &&
                    (min_nxt == alm_min) && (hour_nxt == alm_hour);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fix_flag <= 1'b0;
         alm_flag <= 1'b0;
      end else begin
         fix_flag <= set_fix || (fix_flag && !(ctrl_we && !keep_fix));
         alm_flag <= set_alm || (alm_flag && !(ctrl_we && !keep_alm));
      end
   end

   assign irq = fix_flag || alm_flag;

   AST_FIX_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (fix_flag && ctrl_we && keep_fix) |=> fix_flag); // R10
   AST_ALM_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (alm_flag && ctrl_we && keep_alm) |=> alm_flag); // R10
   AST_FIX_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we && !keep_fix && !step) |=> !fix_flag); // R10
   AST_IRQ_FROM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(step)); // R8
   AST_ALM_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alm_flag) |-> $past(sec_last)); // R9

endmodule

// File: rtl/rtc_hold_core.sv
module rtc_hold_core
   import rtc_pkg::*;
#(
   parameter int unsigned SUB_W    = 15,
   parameter int unsigned YEAR_MAX = 99
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          wr_en,
   input  logic [3:0]    addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          irq
);
   if (SUB_W < 2 || SUB_W > 24) begin : g_bad_sub
      $error("rtc_hold_core: SUB_W out of range");
   end
   if (YEAR_MAX < 3 || YEAR_MAX > 255) begin : g_bad_year
      $error("rtc_hold_core: YEAR_MAX out of range");
   end

   logic          hold, per_min, alm_en, ready, step;
   logic [DW-1:0] alm_min, alm_hour;
   logic [DW-1:0] sec, min, hour, day, month, year;
   logic [DW-1:0] min_nxt, hour_nxt;
   logic          sec_last, fix_flag, alm_flag;
   logic          ctrl_we, sec_clr;
   logic [5:0]    fld_we;

   assign ctrl_we = wr_en && (addr == A_CTRL);

   for (genvar i = 0; i < 6; i++) begin : g_fld_we
      assign fld_we[i] = wr_en && ready && (addr == 4'(i));
   end
   assign sec_clr = fld_we[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold     <= 1'b0;
         per_min  <= 1'b0;
         alm_en   <= 1'b0;
         alm_min  <= '0;
         alm_hour <= '0;
      end else if (wr_en) begin
         if (addr == A_CTRL) begin
            hold    <= wdata[C_HOLD];
            per_min <= wdata[C_PER];
            alm_en  <= wdata[C_AEN];
         end
         if (addr == A_AMIN)  alm_min  <= wdata;
         if (addr == A_AHOUR) alm_hour <= wdata;
      end
   end

   rtc_subsec #(.SUB_W(SUB_W)) u_sub (
      .clk(clk), .rst_n(rst_n), .tick(tick), .hold(hold), .clr(sec_clr),
      .step(step), .ready(ready)
   );

   rtc_calendar #(.YEAR_MAX(YEAR_MAX)) u_cal (
      .clk(clk), .rst_n(rst_n), .step(step), .hold(hold), .fld_we(fld_we),
      .wdata(wdata), .sec(sec), .min(min), .hour(hour), .day(day),
      .month(month), .year(year), .sec_last(sec_last),
      .min_nxt(min_nxt), .hour_nxt(hour_nxt)
   );

   rtc_events u_evt (
      .clk(clk), .rst_n(rst_n), .step(step), .sec_last(sec_last),
      .min_nxt(min_nxt), .hour_nxt(hour_nxt), .alm_min(alm_min),
      .alm_hour(alm_hour), .per_min(per_min), .alm_en(alm_en),
      .ctrl_we(ctrl_we), .keep_fix(wdata[C_FIX]), .keep_alm(wdata[C_ALM]),
      .fix_flag(fix_flag), .alm_flag(alm_flag), .irq(irq)
   );

   always_comb begin
      case (addr)
         A_SEC:   rdata = sec;
         A_MIN:   rdata = min;
         A_HOUR:  rdata = hour;
         A_DAY:   rdata = day;
         A_MONTH: rdata = month;
         A_YEAR:  rdata = year;
         A_AMIN:  rdata = alm_min;
         A_AHOUR: rdata = alm_hour;
         A_CTRL:  rdata = {2'b00, alm_en, per_min, alm_flag, fix_flag, ready, hold};
         default: rdata = '0;
      endcase
   end

   AST_READY_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> hold); // R3

endmodule

// File: tb/sim_rtc_hold_core.sv
module sim_rtc_hold_core;
   localparam int SW = 3;
   localparam int TPS = 1 << SW;   // ticks per second

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] addr = 4'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   bit cfg_per = 0;
   bit cfg_aen = 0;

   always #4 clk = ~clk;

   rtc_hold_core #(.SUB_W(SW), .YEAR_MAX(99)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   function automatic int mlen(int m, int y);
      if (m == 2) return (y % 4 == 0) ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   function automatic logic [7:0] cv(bit h, bit kf, bit ka);
      return {2'b00, cfg_aen, cfg_per, ka, kf, 1'b0, h};
   endfunction

   task automatic chk(string tag, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [3:0] a, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, output int d);
      addr = a;
      #1 d = int'(rdata);
   endtask

   task automatic ticks(int n);
      repeat (n) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic set_time(int y, int mo, int d, int h, int mi, int s);
      wr(4'd8, cv(1, 0, 0));
      ticks(1);
      wr(4'd5, 8'(y)); wr(4'd4, 8'(mo)); wr(4'd3, 8'(d));
      wr(4'd2, 8'(h)); wr(4'd1, 8'(mi)); wr(4'd0, 8'(s));
      wr(4'd8, cv(0, 0, 0));
      cyc(1);
   endtask

   task automatic chk_time(string tag, int y, int mo, int d, int h, int mi, int s);
      int v;
      rd(4'd0, v); chk({tag, " sec"}, v, s);
      rd(4'd1, v); chk({tag, " min"}, v, mi);
      rd(4'd2, v); chk({tag, " hour"}, v, h);
      rd(4'd3, v); chk({tag, " day"}, v, d);
      rd(4'd4, v); chk({tag, " month"}, v, mo);
      rd(4'd5, v); chk({tag, " year"}, v, y);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int v;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);

      // R11 reset state
      chk_time("R11", 0, 1, 1, 0, 0, 0);
      rd(4'd8, v); chk("R11 ctrl", v, 0);
      chk("R11 irq", int'(irq), 0);

      // R2 one second per sub-second wrap
      set_time(1, 1, 1, 0, 0, 0);
      ticks(TPS - 1);
      rd(4'd0, v); chk("R2 before wrap", v, 0);
      ticks(1);
      rd(4'd0, v); chk("R2 after wrap", v, 1);
      rd(4'd8, v); chk("R8 fixed flag per second", (v >> 2) & 1, 1);
      chk("R10 irq follows flag", int'(irq), 1);

      // R3 ready handshake and gated writes
      wr(4'd8, cv(1, 0, 0));
      rd(4'd8, v); chk("R3 ready low before tick", (v >> 1) & 1, 0);
      wr(4'd0, 8'd33);
      rd(4'd0, v); chk("R3 write ignored before ready", v, 1);
      ticks(1);
      rd(4'd8, v); chk("R3 ready after tick", (v >> 1) & 1, 1);
      wr(4'd8, cv(0, 0, 0));
      cyc(1);
      rd(4'd8, v); chk("R3 ready cleared", (v >> 1) & 1, 0);
      wr(4'd0, 8'd44);
      rd(4'd0, v); chk("R3 write ignored without hold", v, 1);

      // R1 / R4 deferred carry, only one stored
      set_time(1, 1, 1, 0, 0, 10);
      wr(4'd8, cv(1, 0, 0));
      ticks(2 * TPS);
      rd(4'd0, v); chk("R1 frozen during hold", v, 10);
      wr(4'd8, cv(0, 0, 0));
      cyc(2);
      rd(4'd0, v); chk("R4 owed second applied", v, 11);
      ticks(TPS);
      rd(4'd0, v); chk("R4 single owed second", v, 12);

      // R5 seconds write cancels owed second
      wr(4'd8, cv(1, 0, 0));
      ticks(TPS);
      wr(4'd0, 8'd30);
      wr(4'd8, cv(0, 0, 0));
      cyc(2);
      rd(4'd0, v); chk("R5 owed second dropped", v, 30);
      ticks(TPS - 1);
      rd(4'd0, v); chk("R5 phase restarted", v, 30);
      ticks(1);
      rd(4'd0, v); chk("R5 next second", v, 31);

      // R6 partial chain
      set_time(7, 5, 14, 10, 59, 59);
      ticks(TPS);
      chk_time("R6 hour carry", 7, 5, 14, 11, 0, 0);

      // R6 / R7 month-end sweep over a common and a leap year
      for (int y = 3; y <= 4; y++) begin
         for (int m = 1; m <= 12; m++) begin
            set_time(y, m, mlen(m, y), 23, 59, 59);
            ticks(TPS);
            chk_time("R7 month end", (m == 12) ? y + 1 : y, (m % 12) + 1, 1, 0, 0, 0);
         end
      end
      set_time(4, 2, 28, 23, 59, 59);
      ticks(TPS);
      chk_time("R7 leap february", 4, 2, 29, 0, 0, 0);
      set_time(99, 12, 31, 23, 59, 59);
      ticks(TPS);
      chk_time("R6 year wrap", 0, 1, 1, 0, 0, 0);

      // R8 minute period
      cfg_per = 1;
      set_time(1, 1, 1, 3, 4, 58);
      ticks(TPS);
      rd(4'd8, v); chk("R8 no flag mid-minute", (v >> 2) & 1, 0);
      ticks(TPS);
      rd(4'd8, v); chk("R8 flag at minute", (v >> 2) & 1, 1);

      // R9 alarm
      cfg_aen = 1;
      wr(4'd6, 8'd10); wr(4'd7, 8'd5);
      set_time(1, 1, 1, 6, 9, 58);
      ticks(2 * TPS);
      rd(4'd8, v); chk("R9 no alarm on mismatch", (v >> 3) & 1, 0);
      set_time(1, 1, 1, 5, 9, 58);
      ticks(TPS);
      rd(4'd8, v); chk("R9 no alarm before wrap", (v >> 3) & 1, 0);
      ticks(TPS);
      rd(4'd8, v); chk("R9 alarm on match", (v >> 3) & 1, 1);
      chk("R10 irq with alarm", int'(irq), 1);

      // R10 write-one keeps, write-zero clears
      wr(4'd8, cv(0, 1, 1));
      rd(4'd8, v); chk("R10 both kept", (v >> 2) & 3, 3);
      wr(4'd8, cv(0, 0, 1));
      rd(4'd8, v); chk("R10 fixed cleared alarm kept", (v >> 2) & 3, 2);
      chk("R10 irq still set", int'(irq), 1);
      wr(4'd8, cv(0, 0, 0));
      rd(4'd8, v); chk("R10 both cleared", (v >> 2) & 3, 0);
      chk("R10 irq low", int'(irq), 0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule